// File: doc/BRIEF.md
# Outbound Queue Port Controller

This block serves one host-visible queue port address whose meaning depends on the direction of the access. A host read of the port takes the oldest entry off the outbound post list, which lives in a ring of shared memory. If that list holds nothing, the read returns all ones. A host write to the port adds a frame address to the outbound free list, a second ring in the same memory. Both rings start from one programmable queue base. The post ring lies two FIFO sizes above the base and the free ring three FIFO sizes above it.

The block keeps head and tail byte pointers for both rings. Each pointer steps by 4 and wraps inside the ring. The local processor moves the post head and the free tail through a small write port. The block moves the post tail and the free head itself. While posted messages are pending, the block raises a host interrupt that can be masked. When a host push fills the free ring, it latches a local error/NMI output.

Top module: `oq_port_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: every pointer, the queue base, the mask, `free_full`, `lcl_nmi`, `host_irq`, `post_pending`, `mem_req` and `host_done`.
- R2: A port read (host address 44h, `host_we`=0) with post head equal to post tail raises `host_done` in the cycle after the request, with `host_rdata` = FFFFFFFFh. It issues no memory access and changes no pointer.
- R3: A port read with pointers that differ issues a memory read at base + 2×FIFO_BYTES + post tail. In the cycle after `mem_ack`, `host_done` pulses for one cycle and `host_rdata` holds the fetched word. The post tail shows its +4 value in that same cycle.
- R4: A port write with the free ring not full issues a memory write of `host_wdata` at base + 3×FIFO_BYTES + free head. In the cycle after `mem_ack`, `host_done` pulses and the free head has advanced by 4.
- R5: All pointers are byte offsets that step by 4 and wrap modulo FIFO_BYTES, so 60 advances to 0 when FIFO_BYTES is 64.
- R6: `post_pending` is 1 while post head differs from post tail. `host_irq` equals `post_pending` unless the mask bit (selector 3, data bit 0) is 1.
- R7: A free-head advance that makes the head equal to the free tail sets `free_full` and `lcl_nmi`. `lcl_nmi` stays 1 until a local write to selector 4 with data bit 0 set.
- R8: A port write while `free_full` is 1 raises `host_done` in the next cycle. It makes no memory access, leaves the free head unchanged and sets `lcl_nmi`.
- R9: Local writes (`lcl_we`) decode `lcl_sel` as follows: 0 loads the queue base, 1 loads the post head, 2 loads the free tail, 3 loads the mask bit, and 4 clears the NMI. Low two bits of loaded addresses and pointers are forced to zero. A free-tail load clears `free_full`.
- R10: Host requests to any other address get no `host_done` and start no memory access.
- R11: When a free-tail load lands in the same cycle as a free-head advance, the full check compares the advanced head with the newly loaded tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | One-cycle host access strobe; accepted only when idle |
| host_we | input | 1 | 1 = port write (free push), 0 = port read (post pop) |
| host_addr | input | HOST_AW | Host register offset within the window |
| host_wdata | input | DATA_W | Frame address pushed by a port write |
| host_rdata | output | DATA_W | Read result, valid with host_done |
| host_done | output | 1 | One-cycle completion pulse |
| host_irq | output | 1 | Masked host interrupt |
| post_pending | output | 1 | Unmasked status: post ring not empty |
| mem_req | output | 1 | Shared-memory request, held until mem_ack |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| lcl_we | input | 1 | Local register write strobe |
| lcl_sel | input | 3 | Local register selector |
| lcl_wdata | input | DATA_W | Local register write data |
| lcl_nmi | output | 1 | Latched free-ring overflow error/NMI |
| free_full | output | 1 | Free ring full |
| post_head | output | PTR_W | Post ring head pointer |
| post_tail | output | PTR_W | Post ring tail pointer |
| free_head | output | PTR_W | Free ring head pointer |
| free_tail | output | PTR_W | Free ring tail pointer |

## Verification
The host push and the local processor's free-tail load can both update the free ring in one cycle, and the full decision depends on which tail value is used. The bench waits for the memory acknowledge of a push that would otherwise fill the ring, then drives a tail load in exactly that cycle. The test passes only if the free head advances, the tail takes the new value, and neither `free_full` nor `lcl_nmi` rises. A following plain push that does meet the new tail must then set both flags.

// File: rtl/oq_pkg.sv
// Package: shared selector codes and sequencer states for the outbound
// queue port controller. Assumes a 3-bit local register selector.
package oq_pkg;

    typedef enum logic [2:0] {
        SEL_BASE      = 3'd0,
        SEL_POST_HEAD = 3'd1,
        SEL_FREE_TAIL = 3'd2,
        SEL_MASK      = 3'd3,
        SEL_NMI_CLR   = 3'd4
    } lcl_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_state_e;

    localparam int unsigned PTR_STEP = 4;

endpackage

// File: rtl/oq_ring_ptr.sv
// Module: one ring pointer, a byte offset that either loads a word-aligned
// value or advances by one word. Assumes the ring size is a power of two,
// so the natural wrap of PTR_W bits gives modulo-size behaviour. Load wins
// if both strobes arrive together (never happens in this block).
module oq_ring_ptr
    import oq_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    output logic [PTR_W-1:0] q
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(PTR_STEP);

    // Register the pointer: reset, aligned load, or wrap-around advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= {load_val[PTR_W-1:2], 2'b00};
        end else if (inc) begin
            q <= q + STEP;
        end
    end

endmodule

// File: rtl/oq_seq.sv
// Module: host access sequencer. Accepts a one-cycle host strobe while
// idle, decodes the queue port offset and the direction, runs one shared
// memory transaction when needed, and returns a one-cycle done pulse.
// Assumes the host issues no new strobe until done, and that memory
// holds mem_ack low until it completes and pulses it for one cycle.
module oq_seq
    import oq_pkg::*;
#(
    parameter int                  ADDR_W     = 32,
    parameter int                  DATA_W     = 32,
    parameter int                  HOST_AW    = 8,
    parameter int                  PTR_W      = 6,
    parameter int                  FIFO_BYTES = 64,
    parameter logic [HOST_AW-1:0]  PORT_OFS   = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              post_empty,
    input  logic              free_full,
    input  logic [ADDR_W-1:0] q_base,
    input  logic [PTR_W-1:0]  post_tail,
    input  logic [PTR_W-1:0]  free_head,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic              pop_post,
    output logic              push_free,
    output logic              drop_push
);

    localparam logic [ADDR_W-1:0] POST_OFS = ADDR_W'(2 * FIFO_BYTES);
    localparam logic [ADDR_W-1:0] FREE_OFS = ADDR_W'(3 * FIFO_BYTES);

    seq_state_e state;
    logic       start;

    // Decode an accepted access to the queue port.
    assign start     = (state == ST_IDLE) && host_req && (host_addr == PORT_OFS);
    assign pop_post  = (state == ST_RD) && mem_ack;
    assign push_free = (state == ST_WR) && mem_ack;
    assign drop_push = start && host_we && free_full;

    // Sequence one host access through optional memory traffic to done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            host_rdata <= '0;
            host_done  <= 1'b0;
        end else begin
            host_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (host_we) begin
                            if (free_full) begin
                                host_done <= 1'b1;
                            end else begin
                                state     <= ST_WR;
                                mem_req   <= 1'b1;
                                mem_we    <= 1'b1;
                                mem_addr  <= q_base + FREE_OFS + ADDR_W'(free_head);
                                mem_wdata <= host_wdata;
                            end
                        end else if (post_empty) begin
                            host_done  <= 1'b1;
                            host_rdata <= '1;
                        end else begin
                            state    <= ST_RD;
                            mem_req  <= 1'b1;
                            mem_we   <= 1'b0;
                            mem_addr <= q_base + POST_OFS + ADDR_W'(post_tail);
                        end
                    end
                end
                ST_RD: begin
                    if (mem_ack) begin
                        host_rdata <= mem_rdata;
                        host_done  <= 1'b1;
                        mem_req    <= 1'b0;
                        state      <= ST_IDLE;
                    end
                end
                ST_WR: begin
                    if (mem_ack) begin
                        host_done <= 1'b1;
                        mem_req   <= 1'b0;
                        mem_we    <= 1'b0;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !host_we && post_empty) |=> (host_done && (host_rdata == '1) && !mem_req));

    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && host_we && free_full) |=> (host_done && !mem_req));

    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

endmodule

// File: rtl/oq_flags.sv
// Module: free-ring full flag, latched overflow NMI, and masked host
// interrupt. Assumes full_hit is already evaluated against the tail value
// that will hold after this cycle. Setting wins over clearing.
module oq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic push_free,
    input  logic full_hit,
    input  logic tail_load,
    input  logic drop_push,
    input  logic nmi_clr,
    input  logic mask_we,
    input  logic mask_val,
    input  logic post_pending,
    output logic free_full,
    output logic lcl_nmi,
    output logic host_irq
);

    logic irq_mask;
    logic fill_now;

    assign fill_now = push_free && full_hit;

    // Track whether the free ring is full.
    always_ff @(posedge clk) begin
        if (!rst_n)         free_full <= 1'b0;
        else if (fill_now)  free_full <= 1'b1;
        else if (tail_load) free_full <= 1'b0;
    end

    // Latch the overflow NMI until the local processor clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     lcl_nmi <= 1'b0;
        else if (fill_now || drop_push) lcl_nmi <= 1'b1;
        else if (nmi_clr)               lcl_nmi <= 1'b0;
    end

    // Hold the host interrupt mask bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_mask <= 1'b0;
        else if (mask_we) irq_mask <= mask_val;
    end

    assign host_irq = post_pending && !irq_mask;

    assert_nmi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_nmi && !nmi_clr) |=> lcl_nmi);

    assert_full_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (free_full && !tail_load) |=> free_full);

endmodule

// File: rtl/oq_port_ctrl.sv
// Module: top of the outbound queue port controller. Holds the queue base
// and the four ring pointers, decodes local register writes, and joins
// the host sequencer to the flag logic. Assumes FIFO_BYTES is a power of
// two and lcl_wdata is at least ADDR_W bits wide.
module oq_port_ctrl
    import oq_pkg::*;
#(
    parameter int                 ADDR_W     = 32,
    parameter int                 DATA_W     = 32,
    parameter int                 HOST_AW    = 8,
    parameter int                 FIFO_BYTES = 64,
    parameter logic [HOST_AW-1:0] PORT_OFS   = 8'h44,
    localparam int                PTR_W      = $clog2(FIFO_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_done,
    output logic               host_irq,
    output logic               post_pending,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               lcl_we,
    input  logic [2:0]         lcl_sel,
    input  logic [DATA_W-1:0]  lcl_wdata,
    output logic               lcl_nmi,
    output logic               free_full,
    output logic [PTR_W-1:0]   post_head,
    output logic [PTR_W-1:0]   post_tail,
    output logic [PTR_W-1:0]   free_head,
    output logic [PTR_W-1:0]   free_tail
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(PTR_STEP);

    logic [ADDR_W-1:0] q_base;
    logic [PTR_W-1:0]  lcl_ptr_val;
    logic [PTR_W-1:0]  free_tail_next;
    logic              wr_base, wr_post_head, wr_free_tail, wr_mask, wr_nmi_clr;
    logic              pop_post, push_free, drop_push, full_hit;

    // Decode local register writes by selector.
    assign wr_base      = lcl_we && (lcl_sel == SEL_BASE);
    assign wr_post_head = lcl_we && (lcl_sel == SEL_POST_HEAD);
    assign wr_free_tail = lcl_we && (lcl_sel == SEL_FREE_TAIL);
    assign wr_mask      = lcl_we && (lcl_sel == SEL_MASK);
    assign wr_nmi_clr   = lcl_we && (lcl_sel == SEL_NMI_CLR) && lcl_wdata[0];
    assign lcl_ptr_val  = {lcl_wdata[PTR_W-1:2], 2'b00};

    // Hold the word-aligned queue base.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_base <= '0;
        else if (wr_base) q_base <= {lcl_wdata[ADDR_W-1:2], 2'b00};
    end

    // Compare the advanced free head with the tail as it stands after this cycle.
    assign free_tail_next = wr_free_tail ? lcl_ptr_val : free_tail;
    assign full_hit       = ((free_head + STEP) == free_tail_next);
    assign post_pending   = (post_head != post_tail);

    oq_ring_ptr #(.PTR_W(PTR_W)) u_post_head (
        .clk(clk), .rst_n(rst_n), .inc(1'b0), .load(wr_post_head),
        .load_val(lcl_ptr_val), .q(post_head));

    oq_ring_ptr #(.PTR_W(PTR_W)) u_post_tail (
        .clk(clk), .rst_n(rst_n), .inc(pop_post), .load(1'b0),
        .load_val('0), .q(post_tail));

    oq_ring_ptr #(.PTR_W(PTR_W)) u_free_head (
        .clk(clk), .rst_n(rst_n), .inc(push_free), .load(1'b0),
        .load_val('0), .q(free_head));

    oq_ring_ptr #(.PTR_W(PTR_W)) u_free_tail (
        .clk(clk), .rst_n(rst_n), .inc(1'b0), .load(wr_free_tail),
        .load_val(lcl_ptr_val), .q(free_tail));

    oq_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOST_AW(HOST_AW),
        .PTR_W(PTR_W), .FIFO_BYTES(FIFO_BYTES), .PORT_OFS(PORT_OFS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata),
        .post_empty(!post_pending), .free_full(free_full),
        .q_base(q_base), .post_tail(post_tail), .free_head(free_head),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata),
        .host_rdata(host_rdata), .host_done(host_done),
        .pop_post(pop_post), .push_free(push_free), .drop_push(drop_push));

    oq_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .push_free(push_free), .full_hit(full_hit), .tail_load(wr_free_tail),
        .drop_push(drop_push), .nmi_clr(wr_nmi_clr),
        .mask_we(wr_mask), .mask_val(lcl_wdata[0]),
        .post_pending(post_pending),
        .free_full(free_full), .lcl_nmi(lcl_nmi), .host_irq(host_irq));

    assert_tail_moves_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (post_tail != $past(post_tail)) |-> host_done);

    assert_head_moves_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (free_head != $past(free_head)) |-> host_done);

    assert_idle_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (post_head == post_tail) |-> !host_irq);

endmodule

// File: tb/oq_port_ctrl_bench.sv
// Directed bench for the outbound queue port controller.
module oq_port_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int HOST_AW    = 8;
    localparam int FIFO_BYTES = 64;
    localparam int PTR_W      = 6;
    localparam int MEM_LAT    = 2;
    localparam int WATCHDOG   = 20000;
    localparam logic [31:0] BASE = 32'h100;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_req = 1'b0;
    logic               host_we = 1'b0;
    logic [HOST_AW-1:0] host_addr = '0;
    logic [DATA_W-1:0]  host_wdata = '0;
    logic [DATA_W-1:0]  host_rdata;
    logic               host_done, host_irq, post_pending;
    logic               mem_req, mem_we;
    logic [ADDR_W-1:0]  mem_addr;
    logic [DATA_W-1:0]  mem_wdata;
    logic               mem_ack;
    logic [DATA_W-1:0]  mem_rdata;
    logic               lcl_we = 1'b0;
    logic [2:0]         lcl_sel = '0;
    logic [DATA_W-1:0]  lcl_wdata = '0;
    logic               lcl_nmi, free_full;
    logic [PTR_W-1:0]   post_head, post_tail, free_head, free_tail;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oq_port_ctrl u_oq_port_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_done(host_done),
        .host_irq(host_irq), .post_pending(post_pending),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .lcl_we(lcl_we), .lcl_sel(lcl_sel), .lcl_wdata(lcl_wdata),
        .lcl_nmi(lcl_nmi), .free_full(free_full),
        .post_head(post_head), .post_tail(post_tail),
        .free_head(free_head), .free_tail(free_tail));

    // Shared memory model: fixed latency, one-cycle acknowledge.
    logic [31:0] mem [0:255];
    int          lat_cnt;
    int          mem_ops;
    logic [31:0] last_addr;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC000_0000 | (i << 2);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            lat_cnt   <= 0;
            mem_ops   <= 0;
            last_addr <= '0;
        end else if (mem_req && !mem_ack) begin
            if (lat_cnt == MEM_LAT - 1) begin
                mem_ack   <= 1'b1;
                lat_cnt   <= 0;
                mem_ops   <= mem_ops + 1;
                last_addr <= mem_addr;
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:2]];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic host_access(input logic we, input logic [7:0] addr,
                               input logic [31:0] wd, output logic [31:0] rd,
                               output int waited);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        waited = 0;
        while (!host_done && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        rd = host_rdata;
    endtask

    task automatic lcl_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        lcl_we = 1'b1; lcl_sel = sel; lcl_wdata = d;
        @(negedge clk);
        lcl_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "post_head", 32'(post_head), 0);
        check("R1", "free_tail", 32'(free_tail), 0);
        check("R1", "flags", {28'd0, lcl_nmi, free_full, host_irq, post_pending}, 0);
        check("R1", "mem_req/done", {30'd0, mem_req, host_done}, 0);
    endtask

    task automatic t_empty_read();
        logic [31:0] d; int w; int ops;
        ops = mem_ops;
        host_access(1'b0, 8'h44, '0, d, w);
        check("R2", "empty read data", d, 32'hFFFF_FFFF);
        check("R2", "done latency", 32'(w), 0);
        check("R2", "no memory access", 32'(mem_ops), 32'(ops));
        check("R2", "tail unchanged", 32'(post_tail), 0);
    endtask

    task automatic t_other_offset();
        int seen = 0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            host_req = 1'b1; host_we = k[0]; host_addr = 8'h40; host_wdata = 32'h1234;
            @(negedge clk);
            host_req = 1'b0;
            for (int c = 0; c < 6; c++) begin
                if (host_done || mem_req) seen++;
                @(negedge clk);
            end
        end
        check("R10", "other offset ignored", 32'(seen), 0);
    endtask

    task automatic t_post_read();
        logic [31:0] d; int w;
        lcl_write(3'd0, BASE | 32'h3);
        lcl_write(3'd1, 32'd8);
        check("R9", "post head load", 32'(post_head), 8);
        check("R6", "irq with entries", {30'd0, host_irq, post_pending}, 2'b11);
        host_access(1'b0, 8'h44, '0, d, w);
        check("R3", "first pop data", d, 32'hC000_0180);
        check("R3", "first pop addr", last_addr, BASE + 32'h80);
        check("R3", "tail in done cycle", 32'(post_tail), 4);
        host_access(1'b0, 8'h44, '0, d, w);
        check("R3", "second pop data", d, 32'hC000_0184);
        check("R6", "irq clears when equal", {30'd0, host_irq, post_pending}, 0);
    endtask

    task automatic t_mask();
        logic [31:0] d; int w;
        lcl_write(3'd1, 32'd12);
        lcl_write(3'd3, 32'd1);
        check("R6", "masked irq", {30'd0, host_irq, post_pending}, 2'b01);
        lcl_write(3'd3, 32'd0);
        check("R6", "unmasked irq", 32'(host_irq), 1);
        host_access(1'b0, 8'h44, '0, d, w);
        check("R3", "pop at tail 8", d, 32'hC000_0188);
    endtask

    task automatic t_wrap();
        logic [31:0] d; int w;
        lcl_write(3'd1, 32'd4);
        for (int k = 0; k < 13; k++) host_access(1'b0, 8'h44, '0, d, w);
        check("R5", "last entry before wrap", d, 32'hC000_01BC);
        check("R5", "tail wrapped to 0", 32'(post_tail), 0);
        host_access(1'b0, 8'h44, '0, d, w);
        check("R5", "entry after wrap", d, 32'hC000_0180);
        check("R5", "pending clear", 32'(post_pending), 0);
    endtask

    task automatic t_push_and_full();
        logic [31:0] d; int w; int ops;
        host_access(1'b1, 8'h44, 32'hAAAA_0001, d, w);
        check("R4", "push addr", last_addr, BASE + 32'hC0);
        check("R4", "push data", mem[(BASE + 32'hC0) >> 2], 32'hAAAA_0001);
        check("R4", "head in done cycle", 32'(free_head), 4);
        for (int k = 2; k < 16; k++) host_access(1'b1, 8'h44, 32'hAAAA_0000 + 32'(k), d, w);
        check("R5", "head at 60", 32'(free_head), 60);
        check("R7", "not yet full", {30'd0, free_full, lcl_nmi}, 0);
        host_access(1'b1, 8'h44, 32'hAAAA_0010, d, w);
        check("R7", "head wrapped onto tail", 32'(free_head), 0);
        check("R7", "full and nmi", {30'd0, free_full, lcl_nmi}, 2'b11);
        ops = mem_ops;
        host_access(1'b1, 8'h44, 32'hDEAD_BEEF, d, w);
        check("R8", "drop done latency", 32'(w), 0);
        check("R8", "drop no memory", 32'(mem_ops), 32'(ops));
        check("R8", "drop head kept", 32'(free_head), 0);
        check("R8", "slot kept", mem[(BASE + 32'hC0) >> 2], 32'hAAAA_0001);
        repeat (3) @(negedge clk);
        check("R7", "nmi held", 32'(lcl_nmi), 1);
        lcl_write(3'd4, 32'd1);
        check("R7", "nmi cleared", {30'd0, free_full, lcl_nmi}, 2'b10);
        lcl_write(3'd2, 32'd4);
        check("R9", "tail load clears full", {30'd0, free_full, 1'b0}, 0);
        check("R9", "free tail load", 32'(free_tail), 4);
    endtask

    task automatic t_concurrent();
        logic [31:0] d; int w; int guard;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 8'h44; host_wdata = 32'hBBBB_0001;
        @(negedge clk);
        host_req = 1'b0;
        guard = 0;
        while (!mem_ack && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        lcl_we = 1'b1; lcl_sel = 3'd2; lcl_wdata = 32'd8;
        @(negedge clk);
        lcl_we = 1'b0;
        check("R11", "done with tail load", 32'(host_done), 1);
        check("R11", "head advanced", 32'(free_head), 4);
        check("R11", "tail loaded", 32'(free_tail), 8);
        check("R11", "no false full", {30'd0, free_full, lcl_nmi}, 0);
        host_access(1'b1, 8'h44, 32'hBBBB_0002, d, w);
        check("R7", "fill to new tail", {30'd0, free_full, lcl_nmi}, 2'b11);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_read();
        t_other_offset();
        t_post_read();
        t_mask();
        t_wrap();
        t_push_and_full();
        t_concurrent();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule